// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a physical address by walking a two-level page table held in memory. The address is cut into three fields: the top 10 bits index the outer table, the next 10 bits index an inner table, and the low 12 bits are the byte offset within a 4 KB page. The walker reads the outer entry, uses its frame number to find the inner table page, reads the inner entry there, and joins that entry's frame number with the offset. An entry whose valid bit is clear ends the walk early with a fault that tells which level failed.

A requester hands in one address at a time over a valid/ready channel and collects the result over a second valid/ready channel. A request is taken only when `req_valid_i` and `req_ready_o` are both high at a clock edge. A response stays on the port, unchanged, until `rsp_ready_i` is seen high at an edge. The memory side carries one read at a time. A read address is offered with `mem_req_valid_o` and stays put until `mem_req_ready_i` takes it. The read data comes back later on `mem_rsp_valid_i`, which memory raises for one cycle after any number of cycles. The table base is a plain input and is latched when a request is taken.

Top module: `pt_walker`

## Requirements
- R1: Out of reset, the walker is idle: `req_ready_o` is 1, and `rsp_valid_o` and `mem_req_valid_o` are 0.
- R2: `req_ready_o` is high only while no walk is in progress. A request offered during a walk is ignored and does not change the addresses read or the result.
- R3: The first read of a walk goes to `B + 4*va[31:22]`, where B is the `ptbase_i` value sampled in the cycle the request was accepted. Later changes of `ptbase_i` have no effect on that walk.
- R4: After a valid outer entry E, the second read goes to `{E[31:12], 12'h000} + 4*va[21:12]`. It is issued only after the outer read data has returned.
- R5: After a valid inner entry I, the response carries `rsp_paddr_o = {I[31:12], va[11:0]}` and `rsp_fault_o = 0`.
- R6: An outer entry with bit 0 clear ends the walk with `rsp_fault_o = 1`, `rsp_level_o = 0` and `rsp_paddr_o = 0`, and no second read is made.
- R7: An inner entry with bit 0 clear ends the walk with `rsp_fault_o = 1`, `rsp_level_o = 1` and `rsp_paddr_o = 0`.
- R8: At most one memory read is outstanding. While `mem_req_valid_o` is high and `mem_req_ready_i` is low, the request and its address hold steady. No new read is offered until the data of the last one has returned.
- R9: While `rsp_valid_o` is high and `rsp_ready_i` is low, the response fields hold steady. In the cycle after the response is taken, `req_ready_o` is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ptbase_i | input | 32 | Physical byte address of the outer table |
| req_valid_i | input | 1 | Translation request present |
| req_ready_o | output | 1 | Walker can take a request |
| req_vaddr_i | input | 32 | Logical address to translate |
| rsp_valid_o | output | 1 | Result present |
| rsp_ready_i | input | 1 | Requester takes the result |
| rsp_paddr_o | output | 32 | Physical address, 0 on a fault |
| rsp_fault_o | output | 1 | Walk ended on an invalid entry |
| rsp_level_o | output | 1 | Failing level: 0 outer, 1 inner |
| mem_req_valid_o | output | 1 | Read address present |
| mem_req_ready_i | input | 1 | Memory takes the read address |
| mem_req_addr_o | output | 32 | Byte address of the entry to read |
| mem_rsp_valid_i | input | 1 | Read data present, one cycle |
| mem_rsp_data_i | input | 32 | Entry read from memory |

## Verification
The bench stalls the memory address channel and spreads read latency at random. A walker that dropped or changed its read while stalled, or started a second read early, would show a wrong or extra address in the read log. It changes `ptbase_i` right after acceptance and offers a second request during a walk. A design that did not latch the base, or that took a request while busy, would read from the wrong table. It also forces invalid entries at each level and uses all-zero and all-one addresses. A design that mixed up the fault level, read the inner table after an outer fault, or cut the offset or index fields at the wrong bits would return a wrong result. Responses are held back at random to catch fields that change before they are taken.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_OUTER = 2'd1,
    ST_INNER = 2'd2,
    ST_DONE  = 2'd3
  } walk_state_e;

  localparam int unsigned LVL_OUTER = 0;
  localparam int unsigned LVL_INNER = 1;

endpackage

// File: rtl/pt_va_split.sv
module pt_va_split #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned OFF_W  = 12
) (
  input  logic [ADDR_W-1:0] vaddr_i,
  output logic [IDX_W-1:0]  outer_idx_o,
  output logic [IDX_W-1:0]  inner_idx_o,
  output logic [OFF_W-1:0]  offset_o
);
  localparam int unsigned INNER_LSB = OFF_W;
  localparam int unsigned OUTER_LSB = OFF_W + IDX_W;

  assign offset_o    = vaddr_i[OFF_W-1:0];
  assign inner_idx_o = vaddr_i[INNER_LSB +: IDX_W];
  assign outer_idx_o = vaddr_i[OUTER_LSB +: IDX_W];
endmodule

// File: rtl/pt_entry_addr.sv
module pt_entry_addr #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned PTE_W  = 32
) (
  input  logic [ADDR_W-1:0] table_base_i,
  input  logic [IDX_W-1:0]  index_i,
  output logic [ADDR_W-1:0] entry_addr_o
);
  localparam int unsigned SHIFT = $clog2(PTE_W / 8);
  localparam int unsigned PAD_W = ADDR_W - IDX_W - SHIFT;

  logic [ADDR_W-1:0] byte_off;

  generate
    if (SHIFT == 0) begin : g_noshift
      assign byte_off = {{PAD_W{1'b0}}, index_i};
    end else begin : g_shift
      assign byte_off = {{PAD_W{1'b0}}, index_i, {SHIFT{1'b0}}};
    end
  endgenerate

  assign entry_addr_o = table_base_i + byte_off;
endmodule

// File: rtl/pt_pte_decode.sv
module pt_pte_decode #(
  parameter int unsigned PTE_W = 32,
  parameter int unsigned OFF_W = 12
) (
  input  logic [PTE_W-1:0]       pte_i,
  output logic [PTE_W-OFF_W-1:0] frame_o,
  output logic                   valid_o,
  output logic [OFF_W-2:0]       attr_o
);
  assign frame_o = pte_i[PTE_W-1:OFF_W];
  assign valid_o = pte_i[0];
  assign attr_o  = pte_i[OFF_W-1:1];
endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
  import pt_walker_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       ptbase_i,
  input  logic                    req_valid_i,
  output logic                    req_ready_o,
  input  logic [ADDR_W-1:0]       req_vaddr_i,
  output logic                    rsp_valid_o,
  input  logic                    rsp_ready_i,
  output logic [ADDR_W-1:0]       rsp_paddr_o,
  output logic                    rsp_fault_o,
  output logic                    rsp_level_o,
  output logic                    mem_req_valid_o,
  input  logic                    mem_req_ready_i,
  output logic [ADDR_W-1:0]       mem_req_addr_o,
  input  logic                    mem_rsp_valid_i,
  input  logic [ADDR_W-OFF_W-1:0] pte_frame_i,
  input  logic                    pte_valid_i,
  input  logic [ADDR_W-1:0]       outer_addr_i,
  input  logic [ADDR_W-1:0]       inner_addr_i,
  output logic [ADDR_W-1:0]       vaddr_q_o,
  output logic [ADDR_W-1:0]       base_q_o,
  output logic [ADDR_W-OFF_W-1:0] inner_tbl_o
);
  localparam int unsigned FRAME_W = ADDR_W - OFF_W;

  walk_state_e         state_q;
  logic                issued_q;
  logic [ADDR_W-1:0]   va_q;
  logic [ADDR_W-1:0]   base_q;
  logic [FRAME_W-1:0]  tbl_q;
  logic [ADDR_W-1:0]   paddr_q;
  logic                fault_q;
  logic                level_q;
  logic                rd_data_ok;

  assign req_ready_o     = (state_q == ST_IDLE);
  assign rsp_valid_o     = (state_q == ST_DONE);
  assign mem_req_valid_o = ((state_q == ST_OUTER) || (state_q == ST_INNER)) && !issued_q;
  assign mem_req_addr_o  = (state_q == ST_INNER) ? inner_addr_i : outer_addr_i;
  assign rsp_paddr_o     = paddr_q;
  assign rsp_fault_o     = fault_q;
  assign rsp_level_o     = level_q;
  assign vaddr_q_o       = va_q;
  assign base_q_o        = base_q;
  assign inner_tbl_o     = tbl_q;
  assign rd_data_ok      = issued_q && mem_rsp_valid_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      issued_q <= 1'b0;
      va_q     <= '0;
      base_q   <= '0;
      tbl_q    <= '0;
      paddr_q  <= '0;
      fault_q  <= 1'b0;
      level_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            va_q     <= req_vaddr_i;
            base_q   <= ptbase_i;
            issued_q <= 1'b0;
            state_q  <= ST_OUTER;
          end
        end
        ST_OUTER: begin
          if (mem_req_valid_o && mem_req_ready_i) issued_q <= 1'b1;
          if (rd_data_ok) begin
            issued_q <= 1'b0;
            if (pte_valid_i) begin
              tbl_q   <= pte_frame_i;
              state_q <= ST_INNER;
            end else begin
              paddr_q <= '0;
              fault_q <= 1'b1;
              level_q <= 1'(LVL_OUTER);
              state_q <= ST_DONE;
            end
          end
        end
        ST_INNER: begin
          if (mem_req_valid_o && mem_req_ready_i) issued_q <= 1'b1;
          if (rd_data_ok) begin
            issued_q <= 1'b0;
            state_q  <= ST_DONE;
            if (pte_valid_i) begin
              paddr_q <= {pte_frame_i, va_q[OFF_W-1:0]};
              fault_q <= 1'b0;
              level_q <= 1'(LVL_INNER);
            end else begin
              paddr_q <= '0;
              fault_q <= 1'b1;
              level_q <= 1'(LVL_INNER);
            end
          end
        end
        ST_DONE: begin
          if (rsp_ready_i) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o) |=> (!req_ready_o && mem_req_valid_o));

  // R3
  outer_base_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o) |=> (base_q == $past(ptbase_i)));

  // R8
  mem_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));

  // R8
  one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid_o && mem_req_ready_i) |=> !mem_req_valid_o);

  // R6
  outer_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OUTER && rd_data_ok && !pte_valid_i)
      |=> (rsp_valid_o && rsp_fault_o && !rsp_level_o && rsp_paddr_o == '0));

  // R7
  inner_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_INNER && rd_data_ok && !pte_valid_i)
      |=> (rsp_valid_o && rsp_fault_o && rsp_level_o));

  // R5
  good_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_INNER && rd_data_ok && pte_valid_i)
      |=> (rsp_valid_o && !rsp_fault_o && rsp_paddr_o[OFF_W-1:0] == va_q[OFF_W-1:0]));

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_ready_i)
      |=> (rsp_valid_o && $stable(rsp_paddr_o) && $stable(rsp_fault_o) && $stable(rsp_level_o)));

  // R9
  rsp_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && rsp_ready_i) |=> req_ready_o);
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned OFF_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ptbase_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_vaddr_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [ADDR_W-1:0] rsp_paddr_o,
  output logic              rsp_fault_o,
  output logic              rsp_level_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [ADDR_W-1:0] mem_rsp_data_i
);
  localparam int unsigned PTE_W   = ADDR_W;
  localparam int unsigned FRAME_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0]  va_q;
  logic [ADDR_W-1:0]  base_q;
  logic [FRAME_W-1:0] tbl_q;
  logic [IDX_W-1:0]   outer_idx;
  logic [IDX_W-1:0]   inner_idx;
  logic [OFF_W-1:0]   offset;
  logic [ADDR_W-1:0]  outer_addr;
  logic [ADDR_W-1:0]  inner_addr;
  logic [FRAME_W-1:0] pte_frame;
  logic               pte_valid;
  logic [OFF_W-2:0]   pte_attr;

  pt_va_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_split (
    .vaddr_i     (va_q),
    .outer_idx_o (outer_idx),
    .inner_idx_o (inner_idx),
    .offset_o    (offset)
  );

  pt_entry_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .PTE_W(PTE_W)) u_outer_addr (
    .table_base_i (base_q),
    .index_i      (outer_idx),
    .entry_addr_o (outer_addr)
  );

  pt_entry_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .PTE_W(PTE_W)) u_inner_addr (
    .table_base_i ({tbl_q, {OFF_W{1'b0}}}),
    .index_i      (inner_idx),
    .entry_addr_o (inner_addr)
  );

  pt_pte_decode #(.PTE_W(PTE_W), .OFF_W(OFF_W)) u_decode (
    .pte_i   (mem_rsp_data_i),
    .frame_o (pte_frame),
    .valid_o (pte_valid),
    .attr_o  (pte_attr)
  );

  pt_walk_ctrl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ctrl (
    .clk             (clk),
    .rst_n           (rst_n),
    .ptbase_i        (ptbase_i),
    .req_valid_i     (req_valid_i),
    .req_ready_o     (req_ready_o),
    .req_vaddr_i     (req_vaddr_i),
    .rsp_valid_o     (rsp_valid_o),
    .rsp_ready_i     (rsp_ready_i),
    .rsp_paddr_o     (rsp_paddr_o),
    .rsp_fault_o     (rsp_fault_o),
    .rsp_level_o     (rsp_level_o),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_req_addr_o  (mem_req_addr_o),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .pte_frame_i     (pte_frame),
    .pte_valid_i     (pte_valid),
    .outer_addr_i    (outer_addr),
    .inner_addr_i    (inner_addr),
    .vaddr_q_o       (va_q),
    .base_q_o        (base_q),
    .inner_tbl_o     (tbl_q)
  );

  // R5
  offset_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_fault_o) |-> (rsp_paddr_o[OFF_W-1:0] == offset));
endmodule

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ptbase_i = '0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_vaddr_i = '0;
  logic        rsp_valid_o;
  logic        rsp_ready_i = 1'b0;
  logic [31:0] rsp_paddr_o;
  logic        rsp_fault_o;
  logic        rsp_level_o;
  logic        mem_req_valid_o;
  logic        mem_req_ready_i = 1'b0;
  logic [31:0] mem_req_addr_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic [31:0] mem_rsp_data_i = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker u_pt_walker (.*);

  int          n_tests = 0;
  int          n_fail  = 0;
  bit          done    = 0;
  logic [31:0] salt    = 32'h1357_2468;
  bit          ov_en [2];
  logic [31:0] ov_adr [2];
  logic [31:0] ov_val [2];
  logic [31:0] rd_log [4];
  int          n_rd  = 0;
  int          pend  = 0;
  logic [31:0] pend_adr = '0;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [31:0] h;
    for (int k = 0; k < 2; k++) if (ov_en[k] && ov_adr[k] == a) return ov_val[k];
    h = (a ^ salt) * 32'h045d_9f3b;
    h = h ^ (h >> 16);
    h = h * 32'h2c1b_3c6d;
    return {h[31:12], h[11:1], (h[2:0] != 3'd0)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // memory model: random address stall, random read latency
  initial begin
    forever begin
      @(negedge clk);
      mem_rsp_valid_i = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          mem_rsp_valid_i = 1'b1;
          mem_rsp_data_i  = mem_word(pend_adr);
        end
      end
      mem_req_ready_i = ($urandom % 3) != 0;
      if (mem_req_valid_o && mem_req_ready_i) begin
        // R8: no second read while one is outstanding
        if (pend != 0 || mem_rsp_valid_i) chk(0, "R8 overlap", mem_req_addr_o, pend_adr);
        pend_adr = mem_req_addr_o;
        pend     = 1 + ($urandom % 4);
        if (n_rd < 4) rd_log[n_rd] = mem_req_addr_o;
        n_rd++;
      end
    end
  end

  task automatic walk(input logic [31:0] va, input logic [31:0] base, input bit poke);
    logic [31:0] oa, oe, ia, ie, exp_pa;
    bit          exp_f, exp_l;
    int          exp_n, hold;
    logic [31:0] pa0;
    logic        f0, l0;
    oa = base + {20'd0, va[31:22], 2'b00};
    oe = mem_word(oa);
    ia = {oe[31:12], 12'h000} + {20'd0, va[21:12], 2'b00};
    ie = mem_word(ia);
    if (!oe[0])      begin exp_f = 1; exp_l = 0; exp_pa = 0; exp_n = 1; end
    else if (!ie[0]) begin exp_f = 1; exp_l = 1; exp_pa = 0; exp_n = 2; end
    else             begin exp_f = 0; exp_l = 1; exp_pa = {ie[31:12], va[11:0]}; exp_n = 2; end
    n_rd = 0;
    @(negedge clk);
    req_valid_i = 1'b1; req_vaddr_i = va; ptbase_i = base;
    while (!req_ready_o) @(negedge clk);
    @(negedge clk);
    ptbase_i = ~base;                       // R3: later base change ignored
    if (poke) begin
      req_vaddr_i = ~va;                    // R2: request during walk ignored
      chk(req_ready_o == 1'b0, "R2 busy ready", {31'd0, req_ready_o}, 32'd0);
    end else req_valid_i = 1'b0;
    while (!rsp_valid_o) @(negedge clk);
    req_valid_i = 1'b0;
    chk(n_rd == exp_n, exp_f && !exp_l ? "R6 read count" : "R4 read count", n_rd, exp_n);
    chk(rd_log[0] == oa, "R3 outer addr", rd_log[0], oa);
    if (exp_n == 2) chk(rd_log[1] == ia, "R4 inner addr", rd_log[1], ia);
    chk(rsp_fault_o == exp_f, exp_l ? "R7 fault" : "R6 fault", {31'd0, rsp_fault_o}, {31'd0, exp_f});
    if (exp_f) chk(rsp_level_o == exp_l, exp_l ? "R7 level" : "R6 level", {31'd0, rsp_level_o}, {31'd0, exp_l});
    chk(rsp_paddr_o == exp_pa, exp_f ? "R6/R7 paddr zero" : "R5 paddr", rsp_paddr_o, exp_pa);
    pa0 = rsp_paddr_o; f0 = rsp_fault_o; l0 = rsp_level_o;
    hold = $urandom % 3;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      chk(rsp_valid_o && rsp_paddr_o == pa0 && rsp_fault_o == f0 && rsp_level_o == l0,
          "R9 hold", rsp_paddr_o, pa0);
    end
    rsp_ready_i = 1'b1;
    @(negedge clk);
    rsp_ready_i = 1'b0;
    chk(req_ready_o && !rsp_valid_o, "R9 release", {31'd0, req_ready_o}, 32'd1);
    chk(n_rd == exp_n, "R8 no extra read", n_rd, exp_n);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < 2; k++) begin ov_en[k] = 0; ov_adr[k] = 0; ov_val[k] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(req_ready_o == 1'b1, "R1 ready", {31'd0, req_ready_o}, 32'd1);
    chk(!rsp_valid_o && !mem_req_valid_o, "R1 idle outputs", {30'd0, rsp_valid_o, mem_req_valid_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready_o && !rsp_valid_o && !mem_req_valid_o, "R1 after release", {31'd0, req_ready_o}, 32'd1);

    // R6: invalid outer entry
    ov_en[0] = 1; ov_adr[0] = 32'h0000_8000 + {20'd0, 10'h155, 2'b00}; ov_val[0] = 32'hABCDE_FFE;
    walk(32'h5540_0123, 32'h0000_8000, 0);
    // R7: valid outer, invalid inner
    ov_val[0] = 32'h12345_001;
    ov_en[1] = 1; ov_adr[1] = 32'h1234_5000 + {20'd0, 10'h2AA, 2'b00}; ov_val[1] = 32'h77777_000;
    walk(32'h556A_A456, 32'h0000_8000, 0);
    // R5: all-ones address, all-ones frame
    ov_en[0] = 1; ov_adr[0] = 32'h0000_1000 + {20'd0, 10'h3FF, 2'b00}; ov_val[0] = 32'h00042_001;
    ov_en[1] = 1; ov_adr[1] = 32'h0004_2000 + {20'd0, 10'h3FF, 2'b00}; ov_val[1] = 32'hFFFFF_001;
    walk(32'hFFFF_FFFF, 32'h0000_1000, 0);
    // R5: all-zero address
    ov_adr[0] = 32'h0000_1000; ov_val[0] = 32'h00099_001;
    ov_adr[1] = 32'h0009_9000; ov_val[1] = 32'h00000_001;
    walk(32'h0000_0000, 32'h0000_1000, 0);
    // R2: request held during a walk
    ov_en[0] = 0; ov_en[1] = 0;
    walk(32'h0123_4567, 32'h0040_0000, 1);

    for (int n = 0; n < 60; n++) begin
      salt = $urandom;
      walk($urandom, {$urandom % 32'h000F_FFFF, 12'h000}, ($urandom % 4) == 0);
    end
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %h expected %h", 32'd1, 32'd0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule